// File: doc/BRIEF.md
# Supply-Pulse Programming Sequence Decoder

This block interprets a serial programming protocol that a tester sends by stepping a device's supply between three voltage levels. Analog comparators outside the block reduce the supply to a 2-bit level code, which arrives once per sample clock. The decoder removes short glitches from that code and measures each pulse and each low gap against minimum widths. It then walks a framed sequence. A high pulse, a run of mid pulses and a closing high pulse pick the programming mode. A second frame of the same shape picks the parameter register. One further high pulse opens bit-field addressing, where each mid pulse advances that register's trial code by one.

In trial mode, a high pulse during addressing goes back to parameter selection, so several registers can be tuned in one power session. In fuse mode, that high pulse is the blow pulse for the addressed bits and closes the session. Out-of-order pulses and unknown keys put the decoder in a sticky error state. A power-cycle input, or reset, clears the error along with the mode, the selection and every trial code.

Top module: `supply_prog_decoder`

## Requirements
- R1: The level code is 00 low, 01 mid, 10 high; 11 is treated as low. A level must hold for more than FILT_LEN consecutive samples before the decoder sees it, so shorter excursions have no effect.
- R2: A mid or high pulse is accepted only if it lasts at least MIN_ACTIVE samples (40 by default, and exactly 40 is accepted). Shorter pulses are ignored.
- R3: A pulse is accepted only if the low gap before it lasts at least MIN_LOW samples. A pulse after a shorter gap, or one entered directly from the other active level, is ignored.
- R4: The first frame is a high pulse, k mid pulses and a high pulse. k=1 sets mode_blow and k=2 sets mode_try. Any other k raises seq_err.
- R5: The next frame is a high pulse, n mid pulses and a high pulse. n of 1, 2, 3 or 5 sets reg_key to n. Any other n raises seq_err.
- R6: After a register is selected, one high pulse raises addr_active. In that state, each accepted mid pulse gives a one-cycle code_inc, and code_val goes up by one once the pulse has returned low.
- R7: Each register's code saturates at 2^bits-1 and produces no code_inc there. The widths are 8 bits for key 1, 9 for key 2, 4 for key 3 and 1 for key 5.
- R8: In trial mode, a high pulse during addressing drops addr_active and returns to parameter selection, where that high pulse counts as the frame opener. Codes are kept per register and show again when the register is reselected.
- R9: In fuse mode, a high pulse during addressing gives exactly one blow_strobe. After that, any accepted pulse raises seq_err.
- R10: A mid pulse where a high pulse is expected raises seq_err. The error holds, with no strobes and no addressing, until reset or power cycle.
- R11: Reset or a pwr_cycle pulse clears the mode, reg_key, addr_active, seq_err and all codes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_cycle | input | 1 | Supply power-cycle indication, synchronous, active high |
| supply_lvl | input | 2 | Classified supply level code |
| mode_try | output | 1 | Trial mode selected |
| mode_blow | output | 1 | Fuse/lock mode selected |
| reg_key | output | 3 | Key of the selected register, 0 if none |
| addr_active | output | 1 | Bit-field addressing in progress |
| code_val | output | CODE_W | Code of the selected register |
| code_inc | output | 1 | One-cycle strobe per accepted code increment |
| blow_strobe | output | 1 | One-cycle strobe for an accepted blow pulse |
| seq_err | output | 1 | Sticky protocol error |

## Verification
The bench sends pulses exactly 39 and 40 samples wide, and a pulse after a 20-sample gap, to expose qualifiers with off-by-one counters or no gap check. Glitches of two and three samples on each active level, plus the unused 11 code, would show up as spurious increments or as an early exit from addressing in a filter that is too short. It drives 17 increments into a 4-bit register and tops up a 1-bit one to catch a counter that wraps to zero. A three-register trial session checks that a looping high pulse is taken as the frame opener and that each code is kept. Misplaced mids, bad keys, pulses after a blow and a power cycle followed by a fresh session check that errors stay set and that codes are cleared.

// File: rtl/prog_dec_pkg.sv
// Shared types and key mapping for the supply-pulse programming decoder.
// Assumes keys fit in three bits; key counts above 7 saturate.
package prog_dec_pkg;

    typedef enum logic [1:0] {
        LV_LOW  = 2'b00,
        LV_MID  = 2'b01,
        LV_HIGH = 2'b10
    } lvl_t;

    typedef enum logic [1:0] {
        M_NONE = 2'd0,
        M_BLOW = 2'd1,
        M_TRY  = 2'd2
    } prog_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MODE_CNT,
        S_PAR_OPEN,
        S_PAR_CNT,
        S_ADDR_OPEN,
        S_ADDR,
        S_DONE,
        S_ERR
    } seq_state_t;

    localparam int KEY_W         = 3;
    localparam int NUM_REGS      = 4;
    localparam int IDX_W         = 2;
    localparam int MODE_KEY_BLOW = 1;
    localparam int MODE_KEY_TRY  = 2;

    // True when a parameter key names an existing register
    function automatic logic key_valid(input logic [KEY_W-1:0] k);
        return (k == 3'd1) || (k == 3'd2) || (k == 3'd3) || (k == 3'd5);
    endfunction

    // Maps a valid parameter key to its register slot
    function automatic logic [IDX_W-1:0] key_to_idx(input logic [KEY_W-1:0] k);
        case (k)
            3'd2:    return 2'd1;
            3'd3:    return 2'd2;
            3'd5:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/lvl_deglitch.sv
// Level deglitcher: passes a classified supply level on only after it has
// been stable for FILT_LEN+1 consecutive samples. The unused code 11 is
// read as low. Assumes FILT_LEN >= 2. Rising and falling edges of the
// output are delayed by the same amount, so pulse widths are preserved.
module lvl_deglitch
    import prog_dec_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_i,
    output lvl_t       lvl_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    lvl_t             raw;
    lvl_t             cand;
    logic [CNT_W-1:0] stab_cnt;

    // Map the raw code into the level type, folding 11 into low
    always_comb begin
        raw = (lvl_i == 2'b11) ? LV_LOW : lvl_t'(lvl_i);
    end

    // Track the candidate level and promote it once it has been stable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand     <= LV_LOW;
            stab_cnt <= '0;
            lvl_o    <= LV_LOW;
        end else if (raw != cand) begin
            cand     <= raw;
            stab_cnt <= '0;
        end else if (stab_cnt < CNT_W'(FILT_LEN - 1)) begin
            stab_cnt <= stab_cnt + 1'b1;
        end else begin
            lvl_o <= cand;
        end
    end

    // The filtered level only changes to a value the raw input held for the last two samples
    p_filter_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != $past(lvl_o)) |-> ($past(raw, 1) == lvl_o && $past(raw, 2) == lvl_o));

endmodule

// File: rtl/pulse_qualifier.sv
// Pulse qualifier: measures each active pulse and the low gap before it on
// the filtered level. When a pulse ends, it emits a one-cycle event of the
// pulse's type if the pulse was at least MIN_ACTIVE samples long and the gap
// before it was at least MIN_LOW samples. Assumes MIN_ACTIVE >= 2.
module pulse_qualifier
    import prog_dec_pkg::*;
#(
    parameter int MIN_ACTIVE = 40,
    parameter int MIN_LOW    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_t lvl_i,
    output logic ev_mid_o,
    output logic ev_high_o
);
    localparam int WW = $clog2(MIN_ACTIVE + 1);
    localparam int LW = $clog2(MIN_LOW + 1);

    lvl_t          prev;
    logic [WW-1:0] wcnt;
    logic [LW-1:0] lcnt;
    logic          gap_ok;
    logic          ending;
    logic          good;

    // A pulse ends when the level leaves the active value it held
    always_comb begin
        ending = (prev != LV_LOW) && (lvl_i != prev);
        good   = gap_ok && (wcnt >= WW'(MIN_ACTIVE));
    end

    // Width and gap counters plus the event generation at the end of a pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= LV_LOW;
            wcnt      <= '0;
            lcnt      <= '0;
            gap_ok    <= 1'b0;
            ev_mid_o  <= 1'b0;
            ev_high_o <= 1'b0;
        end else begin
            prev      <= lvl_i;
            ev_mid_o  <= ending && good && (prev == LV_MID);
            ev_high_o <= ending && good && (prev == LV_HIGH);
            if (lvl_i == LV_LOW) begin
                if (ending) begin
                    lcnt <= LW'(1);
                end else if (lcnt < LW'(MIN_LOW)) begin
                    lcnt <= lcnt + 1'b1;
                end
            end else if (lvl_i != prev) begin
                gap_ok <= (prev == LV_LOW) && (lcnt >= LW'(MIN_LOW));
                wcnt   <= WW'(1);
                lcnt   <= '0;
            end else if (wcnt < WW'(MIN_ACTIVE)) begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    // Events only follow a change of the filtered level
    p_event_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mid_o || ev_high_o) |-> ($past(lvl_i, 1) != $past(lvl_i, 2)));

    // Minimum widths forbid two events in consecutive cycles
    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mid_o || ev_high_o) |=> !(ev_mid_o || ev_high_o));

endmodule

// File: rtl/frame_sequencer.sv
// Frame sequencer: walks the high/mids/high framing for mode and register
// selection, then bit-field addressing. In trial mode a high pulse during
// addressing reopens parameter selection. In fuse mode it is the blow pulse
// and closes the session. Misplaced pulses and unknown keys are sticky errors.
module frame_sequencer
    import prog_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_mid_i,
    input  logic             ev_high_i,
    output logic             mode_try_o,
    output logic             mode_blow_o,
    output logic [KEY_W-1:0] key_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             addr_o,
    output logic             inc_req_o,
    output logic             blow_o,
    output logic             err_o
);
    seq_state_t       state;
    prog_mode_t       mode;
    logic [KEY_W-1:0] cnt;
    logic [KEY_W-1:0] cnt_nxt;

    // Saturating mid-pulse count for the key being framed
    always_comb begin
        cnt_nxt = (cnt == '1) ? cnt : cnt + 1'b1;
    end

    // Protocol state machine with registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            mode      <= M_NONE;
            cnt       <= '0;
            key_o     <= '0;
            idx_o     <= '0;
            inc_req_o <= 1'b0;
            blow_o    <= 1'b0;
        end else begin
            inc_req_o <= 1'b0;
            blow_o    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (ev_high_i) begin
                        state <= S_MODE_CNT;
                        cnt   <= '0;
                    end else if (ev_mid_i) begin
                        state <= S_ERR;
                    end
                end
                S_MODE_CNT: begin
                    if (ev_mid_i) begin
                        cnt <= cnt_nxt;
                    end else if (ev_high_i) begin
                        if (cnt == KEY_W'(MODE_KEY_BLOW)) begin
                            mode  <= M_BLOW;
                            state <= S_PAR_OPEN;
                        end else if (cnt == KEY_W'(MODE_KEY_TRY)) begin
                            mode  <= M_TRY;
                            state <= S_PAR_OPEN;
                        end else begin
                            state <= S_ERR;
                        end
                    end
                end
                S_PAR_OPEN: begin
                    if (ev_high_i) begin
                        state <= S_PAR_CNT;
                        cnt   <= '0;
                    end else if (ev_mid_i) begin
                        state <= S_ERR;
                    end
                end
                S_PAR_CNT: begin
                    if (ev_mid_i) begin
                        cnt <= cnt_nxt;
                    end else if (ev_high_i) begin
                        if (key_valid(cnt)) begin
                            key_o <= cnt;
                            idx_o <= key_to_idx(cnt);
                            state <= S_ADDR_OPEN;
                        end else begin
                            state <= S_ERR;
                        end
                    end
                end
                S_ADDR_OPEN: begin
                    if (ev_high_i) begin
                        state <= S_ADDR;
                    end else if (ev_mid_i) begin
                        state <= S_ERR;
                    end
                end
                S_ADDR: begin
                    if (ev_mid_i) begin
                        inc_req_o <= 1'b1;
                    end else if (ev_high_i) begin
                        if (mode == M_TRY) begin
                            state <= S_PAR_CNT;
                            cnt   <= '0;
                        end else begin
                            blow_o <= 1'b1;
                            state  <= S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    if (ev_mid_i || ev_high_i) begin
                        state <= S_ERR;
                    end
                end
                default: state <= S_ERR;
            endcase
        end
    end

    // Decoded status outputs
    always_comb begin
        mode_try_o  = (mode == M_TRY);
        mode_blow_o = (mode == M_BLOW);
        addr_o      = (state == S_ADDR);
        err_o       = (state == S_ERR);
    end

    // The error state is left only through reset or power cycle
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // Blow strobes only happen in fuse mode
    p_blow_in_fuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blow_o |-> mode_blow_o);

    // After a blow, addressing is closed
    p_single_blow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blow_o |=> (!addr_o && !blow_o));

    // Addressing always runs on a legal register key
    p_key_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o |-> key_valid(key_o));

endmodule

// File: rtl/code_bank.sv
// Code bank: one saturating trial-code counter per parameter register, with
// the width of each taken from its own parameter. Increments that reach a
// saturated counter are dropped without a strobe. Assumes idx_i is stable
// while inc_i is high.
module code_bank
    import prog_dec_pkg::*;
#(
    parameter int SENS_BITS = 8,
    parameter int QDC_BITS  = 9,
    parameter int FREQ_BITS = 4,
    parameter int LOCK_BITS = 1,
    parameter int CODE_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o,
    output logic              inc_o
);
    logic [CODE_W-1:0]   codes [NUM_REGS];
    logic [NUM_REGS-1:0] sat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int B = (g == 0) ? SENS_BITS :
                           (g == 1) ? QDC_BITS  :
                           (g == 2) ? FREQ_BITS : LOCK_BITS;
        logic [B-1:0] c;

        // Saturating counter for this register's trial code
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c <= '0;
            end else if (inc_i && (idx_i == IDX_W'(g)) && !(&c)) begin
                c <= c + 1'b1;
            end
        end

        assign codes[g] = CODE_W'(c);
        assign sat[g]   = &c;

        // A full counter stays full under further increments
        p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i && (idx_i == IDX_W'(g)) && (&c)) |=> (&c));
    end

    // Strobe accepted increments
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_o <= 1'b0;
        end else begin
            inc_o <= inc_i && !sat[idx_i];
        end
    end

    assign code_o = codes[idx_i];

endmodule

// File: rtl/supply_prog_decoder.sv
// Top of the supply-pulse programming decoder: deglitcher, pulse qualifier,
// frame sequencer and code bank in a chain. Reset and power cycle act alike
// and are both synchronous. Assumes one level sample per clock.
module supply_prog_decoder
    import prog_dec_pkg::*;
#(
    parameter int FILT_LEN   = 3,
    parameter int MIN_ACTIVE = 40,
    parameter int MIN_LOW    = 40,
    parameter int SENS_BITS  = 8,
    parameter int QDC_BITS   = 9,
    parameter int FREQ_BITS  = 4,
    parameter int LOCK_BITS  = 1,
    localparam int MAX_AB    = (SENS_BITS > QDC_BITS) ? SENS_BITS : QDC_BITS,
    localparam int MAX_CD    = (FREQ_BITS > LOCK_BITS) ? FREQ_BITS : LOCK_BITS,
    localparam int CODE_W    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_cycle,
    input  logic [1:0]        supply_lvl,
    output logic              mode_try,
    output logic              mode_blow,
    output logic [2:0]        reg_key,
    output logic              addr_active,
    output logic [CODE_W-1:0] code_val,
    output logic              code_inc,
    output logic              blow_strobe,
    output logic              seq_err
);
    logic             clr_n;
    lvl_t             lvl_f;
    logic             ev_mid;
    logic             ev_high;
    logic [IDX_W-1:0] idx;
    logic             inc_req;

    assign clr_n = rst_n && !pwr_cycle;

    lvl_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (clr_n),
        .lvl_i (supply_lvl),
        .lvl_o (lvl_f)
    );

    pulse_qualifier #(.MIN_ACTIVE(MIN_ACTIVE), .MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst_n     (clr_n),
        .lvl_i     (lvl_f),
        .ev_mid_o  (ev_mid),
        .ev_high_o (ev_high)
    );

    frame_sequencer u_seq (
        .clk         (clk),
        .rst_n       (clr_n),
        .ev_mid_i    (ev_mid),
        .ev_high_i   (ev_high),
        .mode_try_o  (mode_try),
        .mode_blow_o (mode_blow),
        .key_o       (reg_key),
        .idx_o       (idx),
        .addr_o      (addr_active),
        .inc_req_o   (inc_req),
        .blow_o      (blow_strobe),
        .err_o       (seq_err)
    );

    code_bank #(
        .SENS_BITS (SENS_BITS),
        .QDC_BITS  (QDC_BITS),
        .FREQ_BITS (FREQ_BITS),
        .LOCK_BITS (LOCK_BITS),
        .CODE_W    (CODE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (clr_n),
        .inc_i  (inc_req),
        .idx_i  (idx),
        .code_o (code_val),
        .inc_o  (code_inc)
    );

    // Increments are only reported while addressing
    p_inc_only_addr_r6: assert property (@(posedge clk) disable iff (!clr_n)
        code_inc |-> addr_active);

    // Every increment strobe matches a one-step code change
    p_code_step_r6: assert property (@(posedge clk) disable iff (!clr_n)
        code_inc |-> (code_val == CODE_W'($past(code_val) + 1'b1)));

    // Mode flags are mutually exclusive
    p_mode_excl_r4: assert property (@(posedge clk) disable iff (!clr_n)
        !(mode_try && mode_blow));

    // The cycle after reset or power cycle shows a cleared decoder
    p_clear_r11: assert property (@(posedge clk)
        !clr_n |=> (!seq_err && !addr_active && !mode_try && !mode_blow && reg_key == 3'd0));

endmodule

// File: tb/supply_prog_decoder_test.sv
// Directed bench for the supply-pulse programming decoder.
module supply_prog_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 50;
    localparam int GAP = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_cycle = 1'b0;
    logic [1:0] supply_lvl = 2'b00;
    logic       mode_try, mode_blow, addr_active, code_inc, blow_strobe, seq_err;
    logic [2:0] reg_key;
    logic [8:0] code_val;

    int n_chk = 0;
    int n_fail = 0;
    int n_inc = 0;
    int n_blow = 0;
    bit done = 1'b0;

    supply_prog_decoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_cycle   (pwr_cycle),
        .supply_lvl  (supply_lvl),
        .mode_try    (mode_try),
        .mode_blow   (mode_blow),
        .reg_key     (reg_key),
        .addr_active (addr_active),
        .code_val    (code_val),
        .code_inc    (code_inc),
        .blow_strobe (blow_strobe),
        .seq_err     (seq_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Strobe counters, sampled away from the active edge
    always @(negedge clk) begin
        if (code_inc) n_inc++;
        if (blow_strobe) n_blow++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] lv, input int width, input int gap_after);
        for (int i = 0; i < width; i++) begin
            @(negedge clk);
            supply_lvl = lv;
        end
        for (int i = 0; i < gap_after; i++) begin
            @(negedge clk);
            supply_lvl = 2'b00;
        end
    endtask

    task automatic hi();
        pulse(2'b10, W, GAP);
    endtask

    task automatic mids(input int n);
        for (int i = 0; i < n; i++) pulse(2'b01, W, GAP);
    endtask

    task automatic frame(input int n);
        hi();
        mids(n);
        hi();
    endtask

    task automatic power_cycle();
        @(negedge clk);
        pwr_cycle = 1'b1;
        supply_lvl = 2'b00;
        repeat (2) @(negedge clk);
        pwr_cycle = 1'b0;
        repeat (GAP + 10) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11", "seq_err after reset", seq_err, 0);
        chk("R11", "modes after reset", {mode_try, mode_blow}, 0);
        chk("R11", "reg_key after reset", reg_key, 0);
        chk("R11", "addr_active after reset", addr_active, 0);
        chk("R11", "code_val after reset", code_val, 0);
    endtask

    task automatic t_try_select();
        int i0;
        frame(2);
        chk("R4", "mode_try after key 2", mode_try, 1);
        chk("R4", "mode_blow after key 2", mode_blow, 0);
        frame(1);
        chk("R5", "reg_key after key 1", reg_key, 1);
        chk("R6", "addr_active before opener", addr_active, 0);
        hi();
        chk("R6", "addr_active after opener", addr_active, 1);
        i0 = n_inc;
        mids(5);
        chk("R6", "code after 5 mids", code_val, 5);
        chk("R6", "strobes for 5 mids", n_inc - i0, 5);
    endtask

    task automatic t_deglitch();
        int i0 = n_inc;
        pulse(2'b01, 2, GAP);
        pulse(2'b10, 3, GAP);
        pulse(2'b11, W, GAP);
        chk("R1", "strobes from glitches", n_inc - i0, 0);
        chk("R1", "addr kept through high glitch", addr_active, 1);
        chk("R1", "code after glitches", code_val, 5);
        mids(1);
        chk("R1", "code after clean mid", code_val, 6);
    endtask

    task automatic t_width();
        pulse(2'b01, 39, GAP);
        chk("R2", "code after 39-sample mid", code_val, 6);
        pulse(2'b01, 40, GAP);
        chk("R2", "code after 40-sample mid", code_val, 7);
    endtask

    task automatic t_gap();
        pulse(2'b01, W, 20);
        chk("R3", "code after mid before short gap", code_val, 8);
        pulse(2'b01, W, GAP);
        chk("R3", "code after mid with short gap", code_val, 8);
        mids(1);
        chk("R3", "code after normal gap", code_val, 9);
    endtask

    task automatic t_saturate();
        int i0;
        hi();
        chk("R8", "addr dropped on loop", addr_active, 0);
        mids(3);
        hi();
        chk("R8", "reg_key after loop select", reg_key, 3);
        hi();
        i0 = n_inc;
        mids(17);
        chk("R7", "4-bit code after 17 mids", code_val, 15);
        chk("R7", "strobes at saturation", n_inc - i0, 15);
    endtask

    task automatic t_loop_retain();
        hi();
        mids(2);
        hi();
        hi();
        mids(3);
        chk("R8", "key 2 code", code_val, 3);
        chk("R8", "reg_key 2", reg_key, 2);
        hi();
        mids(1);
        hi();
        chk("R8", "key 1 code retained", code_val, 9);
        chk("R8", "mode still trial", mode_try, 1);
    endtask

    task automatic t_blow();
        int i0, b0;
        power_cycle();
        frame(1);
        chk("R4", "mode_blow after key 1", mode_blow, 1);
        frame(5);
        chk("R5", "reg_key after key 5", reg_key, 5);
        hi();
        i0 = n_inc;
        mids(3);
        chk("R7", "1-bit code saturates", code_val, 1);
        chk("R7", "strobes for 1-bit code", n_inc - i0, 1);
        b0 = n_blow;
        hi();
        chk("R9", "blow strobes", n_blow - b0, 1);
        chk("R9", "no error at blow", seq_err, 0);
        mids(1);
        chk("R9", "pulse after blow errs", seq_err, 1);
    endtask

    task automatic t_bad_key();
        int i0, b0;
        power_cycle();
        frame(2);
        frame(4);
        chk("R5", "error on key 4", seq_err, 1);
        i0 = n_inc;
        b0 = n_blow;
        hi();
        mids(2);
        hi();
        chk("R10", "no addressing in error", addr_active, 0);
        chk("R10", "no strobes in error", (n_inc - i0) + (n_blow - b0), 0);
        chk("R10", "error held", seq_err, 1);
    endtask

    task automatic t_unexpected();
        power_cycle();
        mids(1);
        chk("R10", "mid first errs", seq_err, 1);
        power_cycle();
        frame(3);
        chk("R4", "mode key 3 errs", seq_err, 1);
        power_cycle();
        frame(1);
        mids(1);
        chk("R10", "mid at parameter opener errs", seq_err, 1);
    endtask

    task automatic t_power();
        power_cycle();
        chk("R11", "error cleared by power cycle", seq_err, 0);
        chk("R11", "modes cleared", {mode_try, mode_blow}, 0);
        chk("R11", "reg_key cleared", reg_key, 0);
        frame(2);
        frame(1);
        hi();
        chk("R11", "trial code cleared", code_val, 0);
        chk("R11", "addressing resumes", addr_active, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (GAP + 10) @(negedge clk);
        t_reset();
        t_try_select();
        t_deglitch();
        t_width();
        t_gap();
        t_saturate();
        t_loop_retain();
        t_blow();
        t_bad_key();
        t_unexpected();
        t_power();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule